// File: doc/BRIEF.md
# Two-Input Mask Boolean Function Unit

This block combines two predicate masks bit by bit with any one of the sixteen two-input boolean functions. The function is picked by a 4-bit truth-table code, and each result bit depends only on the matching bit of the two operands. Because of this, each bit position acts as one independent mask element. The code is the truth table itself, so NAND and NOR are selected directly in one operation, just like AND, OR, XOR, XNOR, AND-NOT and OR-NOT. The cases clear, set, copy and invert need no extra logic: they are simply truth tables that ignore one or both operands.

A caller presents both operands and the code together with a one-cycle `in_valid` strobe. The combined mask shows up on `result` on the next clock edge and `out_valid` is high for that cycle. `result` keeps its value until the next accepted operation. The mask width is set by the `XLEN` parameter.

Top module: `mbf_unit`

## Requirements
- R1: Bit i of the computed mask is `fn[{a[i], b[i]}]`. That is, `fn[0]` is the output when both operand bits are 0, `fn[1]` when only `b` is 1, `fn[2]` when only `a` is 1, and `fn[3]` when both are 1. No bit depends on any other bit position.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and low otherwise.
- R3: On a clock edge where `in_valid` is high, `result` takes the mask computed from that cycle's `a`, `b` and `fn`.
- R4: On a clock edge where `in_valid` is low, `result` keeps its value, whatever `a`, `b` and `fn` are.
- R5: While `rst_n` is low, `result` is all zeros and `out_valid` is low.
- R6: Code 4'h0 gives all zeros and code 4'hF gives all ones, for any operands.
- R7: Code 4'b1100 copies `a`, 4'b1010 copies `b`, 4'b0011 gives `~a` and 4'b0101 gives `~b`.
- R8: Code 4'b1000 gives AND, 4'b1110 OR, 4'b0110 XOR, 4'b0111 NAND, 4'b0001 NOR and 4'b1001 XNOR. XNOR is the same function as `a ^ ~b`.
- R9: Code 4'b0100 gives `a & ~b` and 4'b1101 gives `a | ~b`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and code are valid this cycle |
| fn | input | 4 | Truth-table function code |
| a | input | XLEN | First mask operand |
| b | input | XLEN | Second mask operand |
| result | output | XLEN | Registered combined mask |
| out_valid | output | 1 | `result` was updated on the last edge |

## Verification
The main checks use operand pairs that put all four combinations (00, 01, 10, 11) into different bit positions. With these pairs, a swapped or mis-indexed truth-table bit shows up as a wrong bit at a known position. All sixteen codes are swept across these pairs. Pairs that are all zeros, all ones, or where `a` equals `b` separate functions that are the same on the reduced input set. For example, AND and copy-a look the same when `a` equals `b`, so these pairs show which inputs were actually looked at. Idle cycles with changing operands show whether the hold path leaks new data into `result`.

// File: rtl/mbf_pkg.sv
package mbf_pkg;

    localparam int unsigned FN_W = 4;

    typedef logic [FN_W-1:0] fn_code_t;

    localparam fn_code_t FN_ZERO  = 4'b0000;
    localparam fn_code_t FN_NOR   = 4'b0001;
    localparam fn_code_t FN_NOTA  = 4'b0011;
    localparam fn_code_t FN_ANDN  = 4'b0100;
    localparam fn_code_t FN_NOTB  = 4'b0101;
    localparam fn_code_t FN_XOR   = 4'b0110;
    localparam fn_code_t FN_NAND  = 4'b0111;
    localparam fn_code_t FN_AND   = 4'b1000;
    localparam fn_code_t FN_XNOR  = 4'b1001;
    localparam fn_code_t FN_COPYB = 4'b1010;
    localparam fn_code_t FN_COPYA = 4'b1100;
    localparam fn_code_t FN_ORN   = 4'b1101;
    localparam fn_code_t FN_OR    = 4'b1110;
    localparam fn_code_t FN_ONES  = 4'b1111;

endpackage

// File: rtl/mbf_lane.sv
module mbf_lane
    import mbf_pkg::*;
(
    input  fn_code_t fn,
    input  logic     a_bit,
    input  logic     b_bit,
    output logic     y
);
    // The code is the truth table; the operand pair picks one entry.
    logic [1:0] sel;

    always_comb begin
        sel = {a_bit, b_bit};
        y   = fn[sel];
    end

endmodule

// File: rtl/mbf_array.sv
module mbf_array
    import mbf_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  fn_code_t          fn,
    input  logic [XLEN-1:0]   a,
    input  logic [XLEN-1:0]   b,
    output logic [XLEN-1:0]   y
);
    // One independent lane per mask element.
    for (genvar gi = 0; gi < XLEN; gi++) begin : g_lane
        mbf_lane u_lane (
            .fn    (fn),
            .a_bit (a[gi]),
            .b_bit (b[gi]),
            .y     (y[gi])
        );
    end

endmodule

// File: rtl/mbf_unit.sv
module mbf_unit
    import mbf_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [3:0]      fn,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] result,
    output logic            out_valid
);
    localparam logic [XLEN-1:0] ALL_ZERO = '0;
    localparam logic [XLEN-1:0] ALL_ONE  = '1;

    typedef struct packed {
        logic            vld;
        logic [XLEN-1:0] res;
    } state_t;

    state_t st_d, st_q;
    logic [XLEN-1:0] comb_mask;

    mbf_array #(.XLEN(XLEN)) u_array (
        .fn (fn_code_t'(fn)),
        .a  (a),
        .b  (b),
        .y  (comb_mask)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.res = comb_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{vld: 1'b0, res: ALL_ZERO};
        end else begin
            st_q <= st_d;
        end
    end

    assign result    = st_q.res;
    assign out_valid = st_q.vld;

    // R2: valid follows the strobe by exactly one cycle
    p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R4: idle cycles leave the result untouched
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));
    // R6: constant codes ignore both operands
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fn == FN_ZERO) |=> result == ALL_ZERO);
    p_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fn == FN_ONES) |=> result == ALL_ONE);
    // R7: copy codes forward one operand
    p_copy_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fn == FN_COPYA) |=> result == $past(a));
    p_copy_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fn == FN_COPYB) |=> result == $past(b));
    // R8: NAND is a real single operation
    p_nand_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fn == FN_NAND) |=> result == ~($past(a) & $past(b)));

endmodule

// File: tb/sim_mbf_unit.sv
`timescale 1ns/1ps
module sim_mbf_unit;
    localparam int unsigned W = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [3:0]    fn = 4'h0;
    logic [W-1:0]  a = '0;
    logic [W-1:0]  b = '0;
    logic [W-1:0]  result;
    logic          out_valid;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    mbf_unit #(.XLEN(W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fn(fn),
        .a(a), .b(b), .result(result), .out_valid(out_valid)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference from R1: per bit, entry of fn indexed by {a,b}
    function automatic logic [W-1:0] ref_mask(input logic [3:0] f, input logic [W-1:0] x, input logic [W-1:0] y);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) begin
            r[i] = (!x[i] && !y[i]) ? f[0] :
                   (!x[i] &&  y[i]) ? f[1] :
                   ( x[i] && !y[i]) ? f[2] : f[3];
        end
        return r;
    endfunction

    // One accepted operation; returns result seen the following cycle.
    task automatic issue(input logic [3:0] f, input logic [W-1:0] x, input logic [W-1:0] y,
                         output logic [W-1:0] got);
        @(negedge clk);
        fn = f; a = x; b = y; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 out_valid after strobe", {{(W-1){1'b0}}, out_valid}, 1);
        got = result;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        in_valid = 1'b1; fn = 4'hF; a = '1; b = '1;
        repeat (3) @(negedge clk);
        check("R5 result in reset", result, '0);
        check("R5 out_valid in reset", {{(W-1){1'b0}}, out_valid}, 0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_named();
        logic [W-1:0] x, y, g;
        x = 32'hF0F0_CC33; y = 32'hFF00_AA55;
        issue(4'b1000, x, y, g); check("R8 AND",  g, x & y);
        issue(4'b1110, x, y, g); check("R8 OR",   g, x | y);
        issue(4'b0110, x, y, g); check("R8 XOR",  g, x ^ y);
        issue(4'b0111, x, y, g); check("R8 NAND", g, ~(x & y));
        issue(4'b0001, x, y, g); check("R8 NOR",  g, ~(x | y));
        issue(4'b1001, x, y, g); check("R8 XNOR", g, x ^ ~y);
        issue(4'b0100, x, y, g); check("R9 ANDN", g, x & ~y);
        issue(4'b1101, x, y, g); check("R9 ORN",  g, x | ~y);
    endtask

    task automatic t_degenerate();
        logic [W-1:0] x, y, g;
        x = 32'h1234_5678; y = 32'h9ABC_DEF0;
        issue(4'h0, x, y, g);    check("R6 clear", g, '0);
        issue(4'hF, '0, '0, g);  check("R6 set", g, '1);
        issue(4'b1100, x, y, g); check("R7 copy a", g, x);
        issue(4'b1010, x, y, g); check("R7 copy b", g, y);
        issue(4'b0011, x, y, g); check("R7 not a", g, ~x);
        issue(4'b0101, x, y, g); check("R7 not b", g, ~y);
        issue(4'b1000, x, x, g); check("R7 AND with a==b", g, x);
    endtask

    task automatic t_sweep();
        logic [W-1:0] g;
        logic [W-1:0] pa [3];
        logic [W-1:0] pb [3];
        pa[0] = 32'hCCCC_CCCC; pb[0] = 32'hAAAA_AAAA;
        pa[1] = 32'h0000_0000; pb[1] = 32'hFFFF_FFFF;
        pa[2] = 32'hA5A5_0F0F; pb[2] = 32'h3C3C_00FF;
        for (int p = 0; p < 3; p++) begin
            for (int f = 0; f < 16; f++) begin
                issue(4'(f), pa[p], pb[p], g);
                check("R1 R3 truth-table sweep", g, ref_mask(4'(f), pa[p], pb[p]));
            end
        end
    endtask

    task automatic t_hold();
        logic [W-1:0] g;
        issue(4'b0110, 32'h0F0F_0F0F, 32'h00FF_00FF, g);
        check("R3 value before idle", g, 32'h0FF0_0FF0);
        for (int k = 0; k < 4; k++) begin
            fn = 4'(k * 5); a = 32'hDEAD_0000 + k; b = ~a;
            @(negedge clk);
            check("R4 hold while idle", result, 32'h0FF0_0FF0);
            check("R2 out_valid low while idle", {{(W-1){1'b0}}, out_valid}, 0);
        end
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        fn = 4'b1000; a = 32'hFFFF_0000; b = 32'hFF00_FF00; in_valid = 1'b1;
        @(negedge clk);
        check("R3 first of pair", result, 32'hFF00_0000);
        fn = 4'b1110;
        @(negedge clk);
        in_valid = 1'b0;
        check("R3 second of pair", result, 32'hFFFF_FF00);
        check("R2 valid across pair", {{(W-1){1'b0}}, out_valid}, 1);
        @(negedge clk);
        check("R2 valid drops", {{(W-1){1'b0}}, out_valid}, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_named();
        t_degenerate();
        t_sweep();
        t_hold();
        t_back_to_back();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule